// File: doc/BRIEF.md
# NaN-Aware Packed Compare Unit

This block compares two packed vectors of single-precision values lane by lane. It returns, for each lane, a mask word of all ones when the chosen predicate holds and all zeros when it does not. Eight predicates are available through a 3-bit code. Each lane detects unordered inputs, meaning quiet or signaling NaNs, and gives them the result that belongs to the predicate. Each lane also decides whether its comparison raises the invalid-operation condition.

A one-bit mask input sets what happens on an invalid condition. When the mask is set, the packed result is written. When it is clear, the write is withheld and a trap request is raised for one cycle. A sticky flag records every invalid condition that has been seen. In scalar mode only lane 0 is compared, and the upper lanes of the first operand are copied through unchanged.

Inputs are taken on the clock edge where `in_valid` is high. Results appear one cycle later, together with `out_valid`.

Top module: `fcmp4_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, so the latency is one cycle.
- R2: Predicate codes are EQ=0, LT=1, LE=2, UNORD=3, NEQ=4, NLT=5, NLE=6, ORD=7. For ordered operands, +0 and -0 compare equal, and values are ordered by sign first, then by magnitude. NLT and NLE are the logical inverses of LT and LE. A true lane gives 32'hFFFFFFFF and a false lane gives 32'h00000000.
- R3: A NaN is a value whose exponent field is all ones and whose fraction is nonzero. It is quiet when fraction bit 22 is 1 and signaling when that bit is 0. With EQ or ORD, a NaN in either operand gives an all-zeros lane and never a trap.
- R4: With NEQ or UNORD, a NaN in either operand gives an all-ones lane and never a trap.
- R5: With LT or LE, a NaN of either kind in either operand gives an all-zeros lane when `inv_mask`=1. With NLT or NLE it gives an all-ones lane. In both cases the lane is invalid.
- R6: When `inv_mask`=0 and any active lane is invalid, `out_wr` stays low and `out_data` keeps its previous value in every lane. `trap` is high for exactly one cycle, aligned with `out_valid`. Otherwise a valid result sets `out_wr` high.
- R7: A signaling NaN used with EQ, NEQ, ORD or UNORD makes the lane invalid for the sticky flag but never raises `trap`. A quiet NaN with those predicates does neither.
- R8: With `scalar`=1, only lane 0 is compared and only lane 0 can be invalid. Lanes 1 to 3 of `out_data` take lanes 1 to 3 of `opa`.
- R9: After reset, `out_valid`, `out_wr`, `trap`, `inv_flag` and `out_data` are all zero. `inv_flag` is set by any accepted invalid lane and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are taken this cycle |
| pred | input | 3 | Predicate code |
| scalar | input | 1 | Compare lane 0 only, copy the upper lanes of opa through |
| inv_mask | input | 1 | 1 = invalid masked (write result), 0 = trap on invalid |
| opa | input | 128 | First operand, lane i in bits [32i+31:32i] |
| opb | input | 128 | Second operand |
| out_valid | output | 1 | Result cycle for an accepted operation |
| out_wr | output | 1 | Destination write enable for out_data |
| out_data | output | 128 | Packed mask result, held when not written |
| trap | output | 1 | One-cycle invalid trap request |
| inv_flag | output | 1 | Sticky invalid flag |

## Verification
A table of vectors runs every predicate over lanes that hold equal values, ordered values, signed zeros, negative magnitudes, infinities and NaNs side by side. This separates sign-and-magnitude ordering from raw bit ordering, and shows that each predicate gives the right NaN result whichever operand holds the NaN. Directed runs then pair quiet and signaling NaNs with quiet and relational predicates, with the mask both set and clear. These runs tell "flag only" apart from "trap and hold the output". Scalar runs place NaNs in the upper lanes to show that those lanes are neither compared nor able to trap.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
   typedef enum logic [2:0] {
      PR_EQ    = 3'd0,
      PR_LT    = 3'd1,
      PR_LE    = 3'd2,
      PR_UNORD = 3'd3,
      PR_NEQ   = 3'd4,
      PR_NLT   = 3'd5,
      PR_NLE   = 3'd6,
      PR_ORD   = 3'd7
   } pred_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
   } fclass_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23,
   localparam int W = 1 + EW + FW
) (
   input  logic [W-1:0] x,
   output fclass_t      cls
);
   logic exp_ones;
   logic frac_nz;

   always_comb begin
      exp_ones    = &x[W-2:FW];
      frac_nz     = |x[FW-1:0];
      cls.is_nan  = exp_ones & frac_nz;
      cls.is_snan = exp_ones & frac_nz & ~x[FW-1];
      cls.is_zero = ~|x[W-2:0];
   end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
   import fcmp_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23,
   localparam int W = 1 + EW + FW
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   pred,
   output logic         hit,
   output logic         inv,
   output logic         sig_inv
);
   fclass_t ca, cb;
   logic    unord, eq, lt, base, relational, mag_lt;

   fcmp_classify #(.EW(EW), .FW(FW)) u_ca (.x(a), .cls(ca));
   fcmp_classify #(.EW(EW), .FW(FW)) u_cb (.x(b), .cls(cb));

   always_comb begin
      unord  = ca.is_nan | cb.is_nan;
      mag_lt = a[W-2:0] < b[W-2:0];
      eq     = (a == b) | (ca.is_zero & cb.is_zero);
      if (ca.is_zero & cb.is_zero)  lt = 1'b0;
      else if (a[W-1] != b[W-1])    lt = a[W-1];
      else if (a[W-1])              lt = (b[W-2:0] < a[W-2:0]);
      else                          lt = mag_lt;
      unique case (pred[1:0])
         2'd0:    base = eq & ~unord;
         2'd1:    base = lt & ~unord;
         2'd2:    base = (lt | eq) & ~unord;
         default: base = unord;
      endcase
      hit        = base ^ pred[2];
      relational = (pred[1:0] == 2'd1) | (pred[1:0] == 2'd2);
      sig_inv    = relational & unord;
      inv        = sig_inv | ca.is_snan | cb.is_snan;
   end
endmodule

// File: rtl/fcmp4_unit.sv
module fcmp4_unit
   import fcmp_pkg::*;
#(
   parameter int LANES = 4,
   parameter int EW    = 8,
   parameter int FW    = 23,
   localparam int W    = 1 + EW + FW,
   localparam int DW   = LANES * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [2:0]    pred,
   input  logic          scalar,
   input  logic          inv_mask,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   output logic          out_valid,
   output logic          out_wr,
   output logic [DW-1:0] out_data,
   output logic          trap,
   output logic          inv_flag
);
   if (LANES < 1) begin : g_bad_lanes
      $error("fcmp4_unit: LANES must be at least 1");
   end
   if (EW < 2 || FW < 2) begin : g_bad_fmt
      $error("fcmp4_unit: EW and FW must be at least 2");
   end

   logic [DW-1:0]    res_word;
   logic [LANES-1:0] lane_inv, lane_trap;
   logic             any_inv, any_trap;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic hit, inv, sig_inv, active;
      fcmp_lane #(.EW(EW), .FW(FW)) u_lane (
         .a       (opa[i*W +: W]),
         .b       (opb[i*W +: W]),
         .pred    (pred),
         .hit     (hit),
         .inv     (inv),
         .sig_inv (sig_inv)
      );
      if (i == 0) begin : g_lead
         assign active = 1'b1;
         assign res_word[i*W +: W] = {W{hit}};
      end else begin : g_upper
         assign active = ~scalar;
         assign res_word[i*W +: W] = scalar ? opa[i*W +: W] : {W{hit}};
      end
      assign lane_inv[i]  = active & inv;
      assign lane_trap[i] = active & sig_inv;
   end

   assign any_inv  = |lane_inv;
   assign any_trap = (|lane_trap) & ~inv_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_wr    <= 1'b0;
         trap      <= 1'b0;
         inv_flag  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_wr    <= in_valid & ~any_trap;
         trap      <= in_valid & any_trap;
         if (in_valid & any_inv) inv_flag <= 1'b1;
         if (in_valid & ~any_trap) out_data <= res_word;
      end
   end
endmodule

// File: rtl/fcmp4_unit_chk.sv
module fcmp4_unit_chk #(
   parameter int DW = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic          out_wr,
   input logic [DW-1:0] out_data,
   input logic          trap,
   input logic          inv_flag
);
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r6_wr_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_wr && trap));
   a_r6_trap_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> out_valid);
   a_r6_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !out_wr |-> $stable(out_data));
   a_r6_trap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> inv_flag);
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      inv_flag |=> inv_flag);
endmodule

bind fcmp4_unit fcmp4_unit_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_wr    (out_wr),
   .out_data  (out_data),
   .trap      (trap),
   .inv_flag  (inv_flag)
);

// File: tb/fcmp4_unit_test.sv
module fcmp4_unit_test;
   localparam logic [31:0] P1 = 32'h3f800000, P2 = 32'h40000000, N1 = 32'hbf800000;
   localparam logic [31:0] NH = 32'hbfc00000, PZ = 32'h00000000, NZ = 32'h80000000;
   localparam logic [31:0] QN = 32'h7fc00000, SN = 32'h7f800001, INF = 32'h7f800000;
   localparam logic [31:0] T = 32'hffffffff, F = 32'h00000000;

   typedef struct packed {
      logic [2:0]   p;
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] e;
   } vec_t;

   localparam vec_t VT [10] = '{
      '{3'd0, {P1,PZ,N1,QN},  {P1,NZ,P1,P1},  {T,T,F,F}},
      '{3'd1, {N1,P1,P2,PZ},  {P1,P2,P1,NZ},  {T,T,F,F}},
      '{3'd2, {N1,P2,NZ,P1},  {N1,P1,PZ,INF}, {T,F,T,T}},
      '{3'd1, {N1,NH,N1,P1},  {NH,N1,N1,N1},  {F,T,F,F}},
      '{3'd3, {QN,P1,SN,P1},  {P1,P1,P1,QN},  {T,F,T,T}},
      '{3'd4, {QN,P1,PZ,P1},  {P1,P2,NZ,P1},  {T,T,F,F}},
      '{3'd7, {QN,P1,P1,N1},  {P1,QN,P2,N1},  {F,F,T,T}},
      '{3'd5, {QN,P1,P2,N1},  {P1,P2,P1,N1},  {T,F,T,T}},
      '{3'd6, {P1,P2,P1,INF}, {QN,P1,P1,P1},  {T,T,F,T}},
      '{3'd1, {QN,P1,P1,P1},  {P1,P2,P2,P2},  {F,T,T,T}}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [2:0]   pred = '0;
   logic         scalar = 1'b0;
   logic         inv_mask = 1'b1;
   logic [127:0] opa = '0, opb = '0;
   logic         out_valid, out_wr, trap, inv_flag;
   logic [127:0] out_data;
   int           checks = 0, errors = 0;
   logic [127:0] held;

   always #5 clk = ~clk;

   fcmp4_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred(pred),
      .scalar(scalar), .inv_mask(inv_mask), .opa(opa), .opb(opb),
      .out_valid(out_valid), .out_wr(out_wr), .out_data(out_data),
      .trap(trap), .inv_flag(inv_flag)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic run(input logic [2:0] p, input logic [127:0] a, input logic [127:0] b,
                      input logic m, input logic s);
      @(negedge clk);
      pred = p; opa = a; opb = b; inv_mask = m; scalar = s; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R9 reset state
      check("R9 reset outputs", {124'd0, out_valid, out_wr, trap, inv_flag}, 128'd0);
      check("R9 reset data", out_data, 128'd0);

      // R2..R5 vector table, invalid masked
      foreach (VT[i]) begin
         run(VT[i].p, VT[i].a, VT[i].b, 1'b1, 1'b0);
         check($sformatf("R2 vec %0d data", i), out_data, VT[i].e);
         check($sformatf("R1 vec %0d valid/wr/trap", i), {125'd0, out_valid, out_wr, trap}, 128'd6);
         @(negedge clk);
         check($sformatf("R1 vec %0d valid drop", i), {127'd0, out_valid}, 128'd0);
      end
      check("R5 flag after masked relational NaN", {127'd0, inv_flag}, 128'd1);

      // R3 and R7: quiet NaN with EQ, unmasked -> no trap, no flag
      do_reset();
      run(3'd0, {P1,P1,P1,QN}, {P1,P2,QN,P1}, 1'b0, 1'b0);
      check("R3 EQ qnan data", out_data, {T,F,F,F});
      check("R3 EQ qnan wr/trap/flag", {125'd0, out_wr, trap, inv_flag}, 128'd4);
      // R4 and R7: signaling NaN with UNORD, unmasked -> flag, no trap
      run(3'd3, {P1,SN,P1,P1}, {P1,P1,P1,SN}, 1'b0, 1'b0);
      check("R4 UNORD snan data", out_data, {F,T,F,T});
      check("R7 UNORD snan wr/trap/flag", {125'd0, out_wr, trap, inv_flag}, 128'd5);

      // R6: unmasked relational NaN -> trap, hold data
      do_reset();
      run(3'd0, {P1,P1,P1,P1}, {P1,P2,P1,P2}, 1'b1, 1'b0);
      held = out_data;
      check("R6 prior write", held, {T,F,T,F});
      run(3'd5, {P1,P1,QN,P1}, {P1,P1,P1,P1}, 1'b0, 1'b0);
      check("R6 trap cycle valid/wr/trap", {125'd0, out_valid, out_wr, trap}, 128'd5);
      check("R6 data held", out_data, held);
      check("R5 flag on trap", {127'd0, inv_flag}, 128'd1);
      @(negedge clk);
      check("R6 trap one cycle", {127'd0, trap}, 128'd0);

      // R8 scalar mode: NaNs above lane 0 ignored
      do_reset();
      run(3'd1, {N1,SN,QN,P1}, {QN,QN,SN,P2}, 1'b0, 1'b0 | 1'b1);
      check("R8 scalar data", out_data, {N1,SN,QN,T});
      check("R8 scalar wr/trap/flag", {125'd0, out_wr, trap, inv_flag}, 128'd4);
      run(3'd2, {P2,P2,P2,QN}, {P1,P1,P1,P1}, 1'b0, 1'b1);
      check("R8 scalar lane0 trap", {125'd0, out_valid, out_wr, trap}, 128'd5);
      check("R8 scalar held data", out_data, {N1,SN,QN,T});

      // R9 sticky flag survives clean operations
      run(3'd0, {P1,P1,P1,P1}, {P1,P1,P1,P1}, 1'b1, 1'b0);
      check("R9 flag sticky", {126'd0, out_wr, inv_flag}, 128'd3);
      check("R2 all equal", out_data, {T,T,T,T});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule